// File: doc/BRIEF.md
# Edge-Qualified Pin Interrupt Controller with Pulse Filter

This block watches a group of input pins and raises one shared interrupt request when any enabled pin sees a qualified edge. For each pin, software chooses whether the rising or the falling edge counts. Each pin's level must then stay at the new value for a minimum number of bus clocks before the event is accepted. Short glitches are dropped, so they never reach the pin's flag.

Accepted events set per-pin flags. Software clears a flag by writing a one to it. The OR of all enabled flags drives a registered interrupt request. The same term, gated by a sleep indication, drives a registered wake request, which lets a stopped or waiting system be woken by a pin.

The block does not look at the pad direction. It only sees the level on each pin input, so a pin driven by the chip itself can also raise events. Registers are reached through a simple write strobe and a read address with a registered read port.

Top module: `pinirq_port`

## Requirements
- R1: After reset, the enable, polarity and flag registers read zero, and `irq_o` and `wake_o` are low. A zero polarity bit means falling-edge sensitivity.
- R2: Polarity bit value 1 makes that pin active-high, so a rising edge counts. Value 0 makes it active-low, so a falling edge counts.
- R3: A stay at the active level lasting 1, 2 or 3 bus clocks, entered from the inactive level, sets no flag.
- R4: A stay at the active level lasting 4 or more bus clocks sets the pin's flag exactly once. The pin must go back to the inactive level before it can fire again.
- R5: `irq_o` is high one cycle after any flag bit and its enable bit are both set. A flag whose enable is zero is still recorded but does not raise `irq_o`.
- R6: Writing the flag register clears every bit written as one. Bits written as zero keep their value.
- R7: If a pin qualifies an event in the same cycle as a write that clears its flag, the flag ends up set.
- R8: Changing a pin's polarity bit restarts that pin's filter. A level that becomes active only because of the change sets no flag. A later inactive-then-active stay of 4 clocks does set it.
- R9: `wake_o` is high one cycle after `sleep_i` is high while an enabled flag is pending. It is low whenever `sleep_i` was low in the previous cycle.
- R10: Register addresses are 0 = enable, 1 = polarity, 2 = flags (write one to clear), 3 = unused and reads zero. `rd_data_o` shows the addressed register one cycle after `rd_addr_i` is applied.
- R11: Pin inputs pass through a two-flop synchronizer. For a pin driven active just before clock edge 1 and held, the flag is set at edge 6 and `irq_o` (when enabled) rises at edge 7.
- R12: Pins filter independently. A qualified pulse on one pin sets only that pin's flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NPINS | Raw, asynchronous pin levels |
| sleep_i | input | 1 | System is in a stop or wait state |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | NPINS | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | NPINS | Registered read data |
| irq_o | output | 1 | Combined interrupt request, registered |
| wake_o | output | 1 | Wake request, registered |

## Verification
The filter is driven with active stays of 1, 2, 3, 4, 7 and 12 clocks, on different pins and under both polarities. The 3-clock and 4-clock cases pin the acceptance boundary exactly, and the result on the other pins' flags shows that each pin is isolated. A stay held well past four clocks, then cleared while still active, separates a one-shot filter from one that re-fires on a level. A polarity flip that turns a resting level active distinguishes a filter that restarts from one that keeps counting. A clear timed into the exact cycle of qualification shows which side wins.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE = 2'd0,
    REG_EDGE   = 2'd1,
    REG_FLAGS  = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/pinirq_sync.sv
module pinirq_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[0] <= '0;
          else     stage_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pinirq_filter.sv
module pinirq_filter #(
  parameter int QUAL_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic rise_sel_i,
  output logic hit_o
);
  localparam int CNT_W = $clog2(QUAL_CLKS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CLKS - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(QUAL_CLKS);

  logic             act;
  logic             sel_q;
  logic             sel_chg;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  assign act     = (level_i == rise_sel_i);
  assign sel_chg = (rise_sel_i != sel_q);
  assign hit_o   = act && armed_q && !sel_chg && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      sel_q <= rise_sel_i;
      if (sel_chg) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (!act) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q) begin
        if (hit_o) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // Independent run-length tracker used only by the checks below
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !act || sel_chg) run_q <= '0;
    else if (run_q != FULL)     run_q <= run_q + 1'b1;
  end

  AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (run_q >= LAST)); // R3
  AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (rst)
    hit_o |=> !hit_o); // R4
  AST_SEL_CHANGE_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(sel_chg) |-> !hit_o); // R8
endmodule

// File: rtl/pinirq_regs.sv
module pinirq_regs
  import pinirq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [NPINS-1:0]  hit_i,
  output logic [NPINS-1:0]  en_o,
  output logic [NPINS-1:0]  rise_o,
  output logic [NPINS-1:0]  flag_o,
  output logic [NPINS-1:0]  rd_data_o
);
  logic [NPINS-1:0] en_q, rise_q, flag_q, clr;

  assign clr = (wr_en_i && wr_addr_i == REG_FLAGS) ? wr_data_i : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      rise_q <= '0;
      flag_q <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == REG_ENABLE) en_q   <= wr_data_i;
      if (wr_en_i && wr_addr_i == REG_EDGE)   rise_q <= wr_data_i;
      flag_q <= (flag_q & ~clr) | hit_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else begin
      case (rd_addr_i)
        REG_ENABLE: rd_data_o <= en_q;
        REG_EDGE:   rd_data_o <= rise_q;
        REG_FLAGS:  rd_data_o <= flag_q;
        default:    rd_data_o <= '0;
      endcase
    end
  end

  assign en_o   = en_q;
  assign rise_o = rise_q;
  assign flag_o = flag_q;

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (($past(clr) & ~$past(hit_i)) & flag_q) == '0); // R6
  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (($past(flag_q) & ~$past(clr)) & ~flag_q) == '0); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    ($past(hit_i) & ~flag_q) == '0); // R7
endmodule

// File: rtl/pinirq_port.sv
module pinirq_port
  import pinirq_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CLKS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic              sleep_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NPINS-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NPINS-1:0]  rd_data_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [NPINS-1:0] pin_s, hit, en, rise, flag;
  logic             pending;

  pinirq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(pin_i), .sync_o(pin_s)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      pinirq_filter #(.QUAL_CLKS(QUAL_CLKS)) u_filt (
        .clk(clk), .rst(rst), .level_i(pin_s[p]),
        .rise_sel_i(rise[p]), .hit_o(hit[p])
      );
    end
  endgenerate

  pinirq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .hit_i(hit),
    .en_o(en), .rise_o(rise), .flag_o(flag), .rd_data_o(rd_data_o)
  );

  assign pending = |(flag & en);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o  <= 1'b0;
      wake_o <= 1'b0;
    end else begin
      irq_o  <= pending;
      wake_o <= pending && sleep_i;
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(flag & en))); // R5
  AST_WAKE_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> ($past(sleep_i) && irq_o)); // R9
endmodule

// File: tb/sim_pinirq_port.sv
module sim_pinirq_port;
  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '1;
  logic          sleep = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [NP-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [NP-1:0] rd_data;
  logic          irq, wake;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  pinirq_port #(.NPINS(NP)) u0 (
    .clk(clk), .rst(rst), .pin_i(pins), .sleep_i(sleep),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq), .wake_o(wake)
  );

  // vector: [8] polarity, [7:5] pin, [4:1] active width, [0] expect flag
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 3'd0, 4'd2,  1'b0},
    {1'b0, 3'd0, 4'd3,  1'b0},
    {1'b0, 3'd0, 4'd4,  1'b1},
    {1'b0, 3'd5, 4'd7,  1'b1},
    {1'b1, 3'd2, 4'd3,  1'b0},
    {1'b1, 3'd2, 4'd4,  1'b1},
    {1'b1, 3'd7, 4'd1,  1'b0},
    {1'b1, 3'd3, 4'd12, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [NP-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [NP-1:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [NP-1:0] v;
    logic [NP-1:0] pol_sh;
    idle(4);
    rst = 1'b0;
    idle(4);

    // R1 reset state
    rd(2'd0, v); check("R1 enable", v, 0);
    rd(2'd1, v); check("R1 polarity", v, 0);
    rd(2'd2, v); check("R1 flags", v, 0);
    check("R1 irq", irq, 0);
    check("R1 wake", wake, 0);

    // Table walk: R2 polarity, R3 reject, R4 accept, R12 isolation
    for (int i = 0; i < 8; i++) begin
      logic       pol;
      int         pin;
      int         w;
      logic       ex;
      pol = VEC[i][8];
      pin = int'(VEC[i][7:5]);
      w   = int'(VEC[i][4:1]);
      ex  = VEC[i][0];
      pol_sh = '0;
      pol_sh[pin] = pol;
      wr(2'd1, pol_sh);
      pins = ~pol_sh;
      idle(8);
      wr(2'd2, '1);
      idle(2);
      @(negedge clk);
      pins[pin] = pol;
      repeat (w) @(negedge clk);
      pins[pin] = ~pol;
      idle(10);
      rd(2'd2, v);
      check(ex ? "R4 R2 R12 qualified pulse" : "R3 R2 short pulse",
            v, ex ? (32'd1 << pin) : 0);
      wr(2'd2, '1);
    end

    // Back to all falling, pins idle high
    wr(2'd1, '0);
    pins = '1;
    idle(8);
    wr(2'd2, '1);

    // R11 latency and R5 enable gating
    wr(2'd0, 8'h02);
    idle(4);
    @(negedge clk);
    pins[1] = 1'b0;
    repeat (6) @(negedge clk);
    check("R11 irq before edge 7", irq, 0);
    @(negedge clk);
    check("R11 irq at edge 7", irq, 1);
    pins[1] = 1'b1;
    idle(4);
    wr(2'd0, 8'h00);
    idle(2);
    check("R5 irq low with enable off", irq, 0);
    rd(2'd2, v); check("R5 flag kept while disabled", v, 8'h02);

    // R9 wake
    wr(2'd0, 8'h02);
    sleep = 1'b1;
    idle(2);
    check("R9 wake while asleep", wake, 1);
    sleep = 1'b0;
    idle(2);
    check("R9 wake off when awake", wake, 0);
    check("R5 irq with enable", irq, 1);

    // R6 write-one-to-clear
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R6 zero write keeps", v, 8'h02);
    wr(2'd2, 8'hFD);
    rd(2'd2, v); check("R6 other bits keep", v, 8'h02);
    wr(2'd2, 8'h02);
    rd(2'd2, v); check("R6 one clears", v, 8'h00);
    idle(2);
    check("R5 irq drops after clear", irq, 0);

    // R7 set wins over clear in the same cycle (qualifies at edge 6)
    @(negedge clk);
    pins[6] = 1'b0;
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h40;
    @(negedge clk);
    wr_en = 1'b0;
    pins[6] = 1'b1;
    idle(4);
    rd(2'd2, v); check("R7 set wins", v, 8'h40);
    wr(2'd2, '1);

    // R4 long stay fires once
    @(negedge clk);
    pins[4] = 1'b0;
    idle(10);
    wr(2'd2, 8'h10);
    idle(10);
    rd(2'd2, v); check("R4 no refire while held", v, 8'h00);
    pins[4] = 1'b1;
    idle(6);

    // R8 polarity change with resting high level
    wr(2'd1, 8'h08);
    idle(10);
    rd(2'd2, v); check("R8 no event from polarity change", v, 8'h00);
    pins[3] = 1'b0;
    idle(6);
    pins[3] = 1'b1;
    idle(4);
    pins[3] = 1'b0;
    idle(6);
    rd(2'd2, v); check("R8 later pulse fires", v, 8'h08);

    // R10 map readback
    wr(2'd0, 8'hA5);
    rd(2'd0, v); check("R10 enable readback", v, 8'hA5);
    rd(2'd1, v); check("R10 polarity readback", v, 8'h08);
    rd(2'd3, v); check("R10 unused reads zero", v, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule